// File: doc/BRIEF.md
# Round-Robin Serial ADC Poller

This block sits on the host side of a four-input, 10-bit serial converter that uses a 16-clock frame. It visits the converter's inputs in a fixed rotation and sends one 8-bit command per frame. Each command carries a start marker, the input select code, a polarity flag, a single-ended/pseudo-differential flag and a two-bit power field. The block generates the serial clock and the command line and shifts in each result from the converter's data line. Results come out on a valid/ready port, tagged with the input they belong to.

Chip select stays low for the whole run. The command for the next conversion goes out while the last bits of the current result are still arriving, so one result is produced every 16 serial clocks. After reset the block waits a programmable number of system clocks. It then lowers chip select and sends 16 zero bits, so that the converter is left in a known state before the first start marker. The serial clock runs at a programmable fraction of the system clock, with a ceiling so that a conversion cannot be stretched past the converter's hold limit. When a finished result is still waiting for the consumer, the serial clock is held low so that no result is lost.

Top module: `adc_poll_host`

## Requirements
- R1: While reset is high, and for POR_CYCLES system clocks after it falls, adc_cs_n is 1 and adc_sclk, adc_din and res_valid are 0. After that, adc_cs_n goes low and stays low until the next reset.
- R2: During the first 16 serial-clock cycles after adc_cs_n falls, adc_din is 0. The first 1 (the start marker) is presented at the 17th rising edge of adc_sclk.
- R3: Each command is 8 bits, sent MSB first: 1, SEL2, SEL1, SEL0, cfg_bipolar, cfg_single, cfg_pwr[1], cfg_pwr[0]. adc_din changes only in the system clock in which adc_sclk falls.
- R4: For input i, the select code SEL2..SEL0 is 001 for i=0, 101 for i=1, 010 for i=2 and 110 for i=3. The same codes are used when cfg_single is 1 (input against common) and when it is 0 (input i as the positive side of its pair).
- R5: After each reset the inputs are requested in the order 0, 1, 2, 3, 0, ...
- R6: Consecutive start markers are exactly 16 rising edges of adc_sclk apart.
- R7: A result is the 10 adc_dout values sampled at rising edges 10 through 19 of adc_sclk, counted with the start marker's edge as 1, the first sample being the MSB.
- R8: Every command yields exactly one result. Results come out in command order, and res_chan carries the input named in that command.
- R9: While res_valid is 1 and res_ready is 0, res_valid, res_data and res_chan do not change.
- R10: If a result is ready to complete while the previous one is still unaccepted, adc_sclk is held low and no rising edge occurs until the previous result is accepted.
- R11: Each high phase and each low phase of adc_sclk lasts L system clocks. L is div_half clamped to the range 1 to DIV_MAX.
- R12: res_valid rises in the same system clock as the adc_sclk rising edge that samples the result's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_half | input | DIV_W | Serial clock half period in system clocks |
| cfg_single | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| cfg_bipolar | input | 1 | Polarity flag placed in each command |
| cfg_pwr | input | 2 | Power-mode field placed in each command |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Command bits to the converter |
| adc_dout | input | 1 | Result bits from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 10 | Conversion result |
| res_chan | output | 2 | Input the result belongs to |

## Verification
A frame counter that is off by one shows up at once as start markers that are not 16 edges apart, and as results whose bits are shifted by one position. This is visible on the first result after the flush. A wrong rotation or select table shows up in the first command that reaches the device model, because the model decodes the select code on its own. A tag that is not delayed by one frame makes res_chan disagree with the scoreboard on the first result. A stall that fails lets a serial rising edge through while the output is full, and the scoreboard then sees a result that is missing or overwritten within one frame.

// File: rtl/adc_poll_pkg.sv
`timescale 1ns/1ps
package adc_poll_pkg;

    localparam int RES_W     = 10;
    localparam int CH_W      = 2;
    localparam int CTRL_W    = 8;
    localparam int FRAME_LEN = 16;
    localparam int CYC_W     = $clog2(FRAME_LEN);
    // frame cycle whose rising edge samples the result MSB
    localparam int CAP_FIRST = 9;
    // cycle of the following frame whose rising edge samples the LSB
    localparam int CAP_LAST  = 2;

    typedef enum logic [1:0] {
        PH_WAIT,
        PH_FLUSH,
        PH_FRAME
    } phase_e;

    typedef struct packed {
        logic       single;
        logic       bipolar;
        logic [1:0] pwr;
    } cfg_t;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [RES_W-1:0] data;
    } result_t;

    // input index -> select code (non-binary)
    function automatic logic [2:0] sel_code(input logic [CH_W-1:0] ch);
        return {ch[0], ch[1], ~ch[1]};
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_byte(input logic [CH_W-1:0] ch,
                                                    input cfg_t c);
        return {1'b1, sel_code(ch), c.bipolar, c.single, c.pwr};
    endfunction

endpackage

// File: rtl/adc_poll_clkgen.sv
`timescale 1ns/1ps
module adc_poll_clkgen #(
    parameter int DIV_W   = 10,
    parameter int DIV_MAX = 900
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  logic [DIV_W-1:0] div_half,
    output logic             sclk,
    output logic             rise_ev,
    output logic             fall_ev
);
    localparam logic [DIV_W-1:0] LIM_MAX = DIV_W'(DIV_MAX);

    logic [DIV_W-1:0] lim;
    logic [DIV_W-1:0] cnt;
    logic             at_lim;

    always_comb begin
        lim = div_half;
        if (lim == '0)
            lim = DIV_W'(1);
        if (lim > LIM_MAX)
            lim = LIM_MAX;
        at_lim  = run && (cnt >= lim - DIV_W'(1));
        rise_ev = at_lim && !sclk && !hold;
        fall_ev = at_lim && sclk;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (rise_ev || fall_ev) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else if (!at_lim) begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/adc_poll_seq.sv
`timescale 1ns/1ps
module adc_poll_seq
    import adc_poll_pkg::*;
#(
    parameter int POR_CYCLES = 2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall_ev,
    input  cfg_t                cfg,
    output phase_e              phase,
    output logic [CYC_W-1:0]    cyc,
    output logic                din,
    output logic [CH_W-1:0]     tag,
    output logic                have_prev,
    output logic                run,
    output logic                cs_n
);
    localparam int POR_W = $clog2(POR_CYCLES + 1);
    localparam logic [CYC_W-1:0] CYC_END = CYC_W'(FRAME_LEN - 1);

    logic [POR_W-1:0]  por_cnt;
    logic [CTRL_W-1:0] tx_sh;
    logic [CH_W-1:0]   chan;

    assign din  = tx_sh[CTRL_W-1];
    assign cs_n = (phase == PH_WAIT);
    assign run  = (phase != PH_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_WAIT;
            por_cnt   <= '0;
            cyc       <= '0;
            tx_sh     <= '0;
            chan      <= '0;
            tag       <= '0;
            have_prev <= 1'b0;
        end else begin
            unique case (phase)
                PH_WAIT: begin
                    if (por_cnt == POR_W'(POR_CYCLES - 1))
                        phase <= PH_FLUSH;
                    else
                        por_cnt <= por_cnt + POR_W'(1);
                end
                PH_FLUSH: begin
                    if (fall_ev) begin
                        cyc <= cyc + CYC_W'(1);
                        if (cyc == CYC_END) begin
                            phase <= PH_FRAME;
                            chan  <= '0;
                            tx_sh <= ctrl_byte('0, cfg);
                        end
                    end
                end
                PH_FRAME: begin
                    if (fall_ev) begin
                        cyc <= cyc + CYC_W'(1);
                        if (cyc == CYC_END) begin
                            chan      <= chan + CH_W'(1);
                            tag       <= chan;
                            have_prev <= 1'b1;
                            tx_sh     <= ctrl_byte(chan + CH_W'(1), cfg);
                        end else begin
                            tx_sh <= {tx_sh[CTRL_W-2:0], 1'b0};
                        end
                    end
                end
                default: phase <= PH_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/adc_poll_capture.sv
`timescale 1ns/1ps
module adc_poll_capture
    import adc_poll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_ev,
    input  logic             in_frame,
    input  logic [CYC_W-1:0] cyc,
    input  logic             have_prev,
    input  logic             dout,
    input  logic [CH_W-1:0]  tag,
    input  logic             res_ready,
    output logic             res_valid,
    output result_t          res,
    output logic             hold
);
    logic [RES_W-1:0] rx_sh;
    logic             in_win;
    logic             last_bit;

    always_comb begin
        in_win   = in_frame && ((cyc >= CYC_W'(CAP_FIRST)) ||
                                (have_prev && (cyc <= CYC_W'(CAP_LAST))));
        last_bit = in_frame && have_prev && (cyc == CYC_W'(CAP_LAST));
        hold     = last_bit && res_valid && !res_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh     <= '0;
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            if (res_valid && res_ready)
                res_valid <= 1'b0;
            if (rise_ev && in_win)
                rx_sh <= {rx_sh[RES_W-2:0], dout};
            if (rise_ev && last_bit) begin
                res_valid <= 1'b1;
                res.data  <= {rx_sh[RES_W-2:0], dout};
                res.chan  <= tag;
            end
        end
    end

endmodule

// File: rtl/adc_poll_host.sv
`timescale 1ns/1ps
module adc_poll_host
    import adc_poll_pkg::*;
#(
    parameter int POR_CYCLES = 2000,
    parameter int DIV_W      = 10,
    parameter int DIV_MAX    = 900
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_half,
    input  logic             cfg_single,
    input  logic             cfg_bipolar,
    input  logic [1:0]       cfg_pwr,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    output logic             adc_din,
    input  logic             adc_dout,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [9:0]       res_data,
    output logic [1:0]       res_chan
);
    cfg_t             cfg;
    phase_e           phase;
    logic [CYC_W-1:0] cyc;
    logic [CH_W-1:0]  tag;
    logic             have_prev;
    logic             run;
    logic             hold;
    logic             rise_ev;
    logic             fall_ev;
    result_t          res;

    assign cfg = '{single: cfg_single, bipolar: cfg_bipolar, pwr: cfg_pwr};

    adc_poll_clkgen #(
        .DIV_W   (DIV_W),
        .DIV_MAX (DIV_MAX)
    ) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .hold     (hold),
        .div_half (div_half),
        .sclk     (adc_sclk),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    adc_poll_seq #(
        .POR_CYCLES (POR_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fall_ev   (fall_ev),
        .cfg       (cfg),
        .phase     (phase),
        .cyc       (cyc),
        .din       (adc_din),
        .tag       (tag),
        .have_prev (have_prev),
        .run       (run),
        .cs_n      (adc_cs_n)
    );

    adc_poll_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .rise_ev   (rise_ev),
        .in_frame  (phase == PH_FRAME),
        .cyc       (cyc),
        .have_prev (have_prev),
        .dout      (adc_dout),
        .tag       (tag),
        .res_ready (res_ready),
        .res_valid (res_valid),
        .res       (res),
        .hold      (hold)
    );

    assign res_data = res.data;
    assign res_chan = res.chan;

endmodule

// File: rtl/adc_poll_host_chk.sv
`timescale 1ns/1ps
module adc_poll_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       adc_cs_n,
    input logic       adc_sclk,
    input logic       adc_din,
    input logic       res_valid,
    input logic       res_ready,
    input logic [9:0] res_data,
    input logic [1:0] res_chan
);
    // R1: chip select, once low, stays low until reset
    p_cs_stays_low_r1: assert property (@(posedge clk) disable iff (rst)
        !adc_cs_n |=> !adc_cs_n);

    // R1: serial pins quiet while chip select is high
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> (!adc_sclk && !adc_din));

    // R3: command line moves only with a falling serial clock
    p_din_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(adc_din) |-> $fell(adc_sclk));

    // R9: pending result held until accepted
    p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_data) && $stable(res_chan)));

    // R12: a new result appears together with a serial rising edge
    p_valid_on_rise_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> $rose(adc_sclk));

endmodule

bind adc_poll_host adc_poll_host_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .adc_din   (adc_din),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_chan  (res_chan)
);

// File: tb/sim_adc_poll_host.sv
`timescale 1ns/1ps
module sim_adc_poll_host;

    localparam int POR  = 20;
    localparam int DW   = 10;
    localparam int DMAX = 6;
    localparam int WD_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] div_half = DW'(2);
    logic          cfg_single = 1'b1;
    logic          cfg_bipolar = 1'b0;
    logic [1:0]    cfg_pwr = 2'b11;
    logic          adc_cs_n, adc_sclk, adc_din;
    logic          adc_dout = 1'b0;
    logic          res_valid;
    logic          res_ready = 1'b1;
    logic [9:0]    res_data;
    logic [1:0]    res_chan;

    always #2.5 clk = ~clk;

    adc_poll_host #(
        .POR_CYCLES (POR),
        .DIV_W      (DW),
        .DIV_MAX    (DMAX)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .div_half    (div_half),
        .cfg_single  (cfg_single),
        .cfg_bipolar (cfg_bipolar),
        .cfg_pwr     (cfg_pwr),
        .adc_cs_n    (adc_cs_n),
        .adc_sclk    (adc_sclk),
        .adc_din     (adc_din),
        .adc_dout    (adc_dout),
        .res_valid   (res_valid),
        .res_ready   (res_ready),
        .res_data    (res_data),
        .res_chan    (res_chan)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // ---------------- device model + scoreboard producer ----------------
    int         rise_cnt = 0;
    int         last_start = 0;
    int         first_start = -1;
    bit         armed = 1'b1;
    bit         rx = 1'b0;
    int         rx_bits = 0;
    logic [7:0] rx_byte = '0;
    bit         conv = 1'b0;
    int         fcnt = 0;
    logic [11:0] conv_word = '0;
    int         conv_num = 0;
    int         rr_exp = 0;
    logic       exp_single = 1'b1;
    logic       exp_bip = 1'b0;
    logic [1:0] exp_pwr = 2'b11;
    logic [11:0] sb_q[$];

    task automatic mdl_reset();
        rise_cnt = 0; last_start = 0; first_start = -1;
        armed = 1'b1; rx = 1'b0; rx_bits = 0; conv = 1'b0; fcnt = 0;
        rr_exp = 0; adc_dout = 1'b0;
        sb_q.delete();
    endtask

    task automatic mdl_accept(input logic [7:0] b);
        int ch;
        logic [9:0] val;
        case (b[6:4])
            3'b001:  ch = 0;
            3'b101:  ch = 1;
            3'b010:  ch = 2;
            3'b110:  ch = 3;
            default: ch = -1;
        endcase
        chk(ch >= 0, "R4", "select code valid", int'(b[6:4]), 1);
        chk(ch == rr_exp, "R5", "rotation order", ch, rr_exp);
        chk(b[3] == exp_bip, "R3", "polarity bit", int'(b[3]), int'(exp_bip));
        chk(b[2] == exp_single, "R3", "mode bit", int'(b[2]), int'(exp_single));
        chk(b[1:0] == exp_pwr, "R3", "power field", int'(b[1:0]), int'(exp_pwr));
        rr_exp = (rr_exp + 1) % 4;
        val = 10'((conv_num * 181 + rr_exp * 37 + 5) % 1024);
        conv_num++;
        sb_q.push_back({2'(ch < 0 ? 0 : ch), val});
        conv = 1'b1;
        fcnt = 0;
        conv_word = {val, 2'b00};
    endtask

    always @(posedge adc_sclk) begin
        if (!adc_cs_n) begin
            rise_cnt++;
            if (rx) begin
                rx_byte = {rx_byte[6:0], adc_din};
                rx_bits++;
                if (rx_bits == 8) begin
                    rx = 1'b0;
                    mdl_accept(rx_byte);
                end
            end else if (armed && adc_din) begin
                rx = 1'b1; rx_bits = 1; rx_byte = 8'h01; armed = 1'b0;
                if (first_start < 0) begin
                    first_start = rise_cnt;
                    chk(rise_cnt == 17, "R2", "first start edge", rise_cnt, 17);
                end else begin
                    chk(rise_cnt - last_start == 16, "R6", "start spacing",
                        rise_cnt - last_start, 16);
                end
                last_start = rise_cnt;
            end
        end
    end

    always @(negedge adc_sclk) begin
        if (!adc_cs_n && conv) begin
            fcnt++;
            if (fcnt >= 2 && fcnt <= 13)
                adc_dout <= conv_word[13 - fcnt];
            if (fcnt == 7)
                armed = 1'b1;
            if (fcnt == 13)
                conv = 1'b0;
        end
    end

    // ---------------- monitor ----------------
    int   popped = 0;
    int   din_bad = 0;
    logic prev_valid = 1'b0;
    logic prev_sclk = 1'b0;
    logic prev_din = 1'b0;

    always @(negedge clk) begin
        logic [11:0] e;
        if (rst) begin
            prev_valid = 1'b0;
        end else begin
            if (adc_din !== prev_din && !(prev_sclk == 1'b1 && adc_sclk == 1'b0))
                din_bad++;
            if (res_valid && !prev_valid)
                chk(adc_sclk == 1'b1 && fcnt == 11, "R12",
                    "valid edge vs last-bit sample", fcnt, 11);
            if (res_valid && res_ready) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R8", "result without command", int'(res_data), -1);
                end else begin
                    e = sb_q.pop_front();
                    chk(res_data == e[9:0], "R7", "result data",
                        int'(res_data), int'(e[9:0]));
                    chk(res_chan == e[11:10], "R8", "result tag",
                        int'(res_chan), int'(e[11:10]));
                end
                popped++;
            end
            prev_valid = res_valid;
        end
        prev_sclk = adc_sclk;
        prev_din  = adc_din;
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == WD_LIMIT) begin
            chk(1'b0, "watchdog", "run did not finish", wd, 0);
            report();
        end
    end

    // ---------------- driver ----------------
    task automatic run_seg(input logic single, input logic bip, input logic [1:0] pwr,
                           input int div, input int nres, input bit stall,
                           input bit toggle);
        int n;
        int h;
        int lim;
        int k;
        int r0;
        logic [9:0] d0;
        logic [1:0] c0;
        @(negedge clk);
        rst = 1'b1;
        res_ready = 1'b1;
        cfg_single = single; cfg_bipolar = bip; cfg_pwr = pwr;
        div_half = DW'(div);
        exp_single = single; exp_bip = bip; exp_pwr = pwr;
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0 && adc_din == 1'b0 && res_valid == 1'b0,
            "R1", "reset pin state", int'({adc_cs_n, adc_sclk, adc_din, res_valid}), 8);
        mdl_reset();
        popped = 0;
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (adc_cs_n && n < 10 * POR);
        chk(n == POR, "R1", "clocks until chip select low", n, POR);

        // R11: high phase length
        lim = (div == 0) ? 1 : ((div > DMAX) ? DMAX : div);
        @(posedge adc_sclk);
        h = 0;
        forever begin
            @(negedge clk);
            if (adc_sclk) h++;
            else break;
        end
        chk(h == lim, "R11", "sclk high phase", h, lim);

        if (stall) begin
            while (popped < 3) @(negedge clk);
            @(posedge clk); #1 res_ready = 1'b0;
            repeat (200) @(negedge clk);
            r0 = rise_cnt; d0 = res_data; c0 = res_chan;
            repeat (200) @(negedge clk);
            chk(rise_cnt == r0, "R10", "sclk rises while full", rise_cnt - r0, 0);
            chk(adc_sclk == 1'b0, "R10", "sclk level while full", int'(adc_sclk), 0);
            chk(res_valid == 1'b1 && res_data == d0 && res_chan == c0, "R9",
                "held result", int'(res_data), int'(d0));
            @(posedge clk); #1 res_ready = 1'b1;
        end

        k = 0;
        while (popped < nres) begin
            @(posedge clk);
            #1;
            if (toggle) res_ready = ((k % 5) < 3);
            k++;
        end
        @(posedge clk); #1 res_ready = 1'b1;
    endtask

    initial begin
        run_seg(1'b1, 1'b0, 2'b11, 2, 10, 1'b1, 1'b0);
        run_seg(1'b0, 1'b1, 2'b01, 3, 9, 1'b0, 1'b1);
        run_seg(1'b1, 1'b1, 2'b00, 9, 6, 1'b0, 1'b0);
        chk(din_bad == 0, "R3", "din changes off falling edge", din_bad, 0);
        report();
    end

endmodule